// File: doc/BRIEF.md
# Dual-Processor Mailbox Latch Pair

This block joins a host bus to a co-processor bus through two independent one-byte mailboxes, one for each direction. The host deposits a byte in the downstream mailbox and collects bytes from the upstream mailbox. The co-processor does the opposite: it reads the downstream mailbox and writes the upstream one. Both of its accesses go through a single address window that is mirrored across 256 addresses.

Each mailbox carries a pending flag that is raised by a write and cleared by a read of that mailbox. The downstream flag drives an active-low non-maskable interrupt toward the co-processor. The upstream flag drives an active-high interrupt request toward the host. Both sides share one clock. Reset empties both mailboxes.

Top module: `mbox_pair`

## Requirements
- R1: While reset is asserted and after it is released, both pending flags are clear: `host_irq` is 0, `cop_nmi_n` is 1, and both mailboxes hold 0x00.
- R2: A co-processor access hits the window when `cop_addr[15:8]` equals 0x7F. The low 8 address bits are ignored, so 0x7F00 through 0x7FFF all reach the same mailboxes. A co-processor access outside the window has no effect, and `cop_rdata` is 0x00 whenever no window read is active.
- R3: A host write (`host_sel_n` low, `host_wr` high) loads `host_wdata` into the downstream mailbox at the clock edge. A co-processor read in the window returns that byte combinationally on `cop_rdata`.
- R4: A co-processor write in the window loads `cop_wdata` into the upstream mailbox at the clock edge. A host read (`host_sel_n` low, `host_rd` high) returns that byte combinationally on `host_rdata`. `host_rdata` is 0x00 when no host read is active.
- R5: From the clock edge of a host write until the downstream mailbox is read, `cop_nmi_n` is held low. Each new byte therefore gives a falling edge.
- R6: From the clock edge of a co-processor window write until the upstream mailbox is read, `host_irq` is held high.
- R7: A read of a mailbox clears that mailbox's pending flag at the clock edge and leaves its data unchanged.
- R8: If a mailbox is written and read in the same cycle, the write wins: the flag stays set and the new byte is stored.
- R9: Host read and write strobes have no effect while `host_sel_n` is high.
- R10: The two mailboxes are independent. Reading or writing one never changes the flag or data of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel_n | input | 1 | Host mailbox I/O strobe, active low |
| host_rd | input | 1 | Host read qualifier |
| host_wr | input | 1 | Host write qualifier |
| host_wdata | input | 8 | Host write data (downstream) |
| host_rdata | output | 8 | Host read data (upstream) |
| host_irq | output | 1 | Interrupt request to host, high while upstream pending |
| cop_addr | input | 16 | Co-processor address |
| cop_rd | input | 1 | Co-processor read strobe |
| cop_wr | input | 1 | Co-processor write strobe |
| cop_wdata | input | 8 | Co-processor write data (upstream) |
| cop_rdata | output | 8 | Co-processor read data (downstream) |
| cop_nmi_n | output | 1 | Non-maskable interrupt to co-processor, low while downstream pending |

## Verification
The assertions check on every cycle how each flag moves inside a mailbox: a write sets the flag and stores the byte, a lone read clears the flag, and an idle cycle holds both the flag and the data. At the top level, assertions check that every rise of `host_irq` follows a co-processor write inside the window, and that every fall of `cop_nmi_n` follows a selected host write. Three things can only be shown by the bench's scenarios: the byte values seen across the two buses, mirrored addresses reaching the same mailbox, and accesses outside the window or with the strobe high leaving the stored state untouched. The bench checks these by reading the data back through the normal ports.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Index of each mailbox in the latch array
  localparam int unsigned MB_DOWN = 0;  // host -> co-processor
  localparam int unsigned MB_UP   = 1;  // co-processor -> host
  localparam int unsigned MB_NUM  = 2;
endpackage

// File: rtl/mbox_latch.sv
module mbox_latch #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] data,
  output logic          pending
);
  logic [DW-1:0] data_nxt;
  logic          pend_nxt;

  // Next state: a write wins over a simultaneous read
  always_comb begin
    data_nxt = data;
    pend_nxt = pending;
    if (rd_en) pend_nxt = 1'b0;
    if (wr_en) begin
      data_nxt = wdata;
      pend_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data    <= '0;
      pending <= 1'b0;
    end else begin
      data    <= data_nxt;
      pending <= pend_nxt;
    end
  end

  // R8
  wr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pending && data == $past(wdata)));
  // R7
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> (!pending && $stable(data)));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |=> ($stable(pending) && $stable(data)));
endmodule

// File: rtl/mbox_cop_decode.sv
module mbox_cop_decode #(
  parameter int unsigned AW       = 16,
  parameter int unsigned IGN_BITS = 8,
  parameter logic [AW-IGN_BITS-1:0] WIN_TAG = 8'h7F
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output logic          rd_hit,
  output logic          wr_hit
);
  localparam int unsigned TAG_W = AW - IGN_BITS;

  logic [TAG_W-1:0] tag;
  logic             in_win;

  always_comb begin
    tag    = addr[AW-1:IGN_BITS];
    in_win = (tag == WIN_TAG);
    rd_hit = rd & in_win;
    wr_hit = wr & in_win;
  end
endmodule

// File: rtl/mbox_host_decode.sv
module mbox_host_decode (
  input  logic sel_n,
  input  logic rd,
  input  logic wr,
  output logic rd_hit,
  output logic wr_hit
);
  always_comb begin
    rd_hit = ~sel_n & rd;
    wr_hit = ~sel_n & wr;
  end
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 16,
  parameter int unsigned IGN_BITS = 8,
  parameter logic [AW-IGN_BITS-1:0] WIN_TAG = 8'h7F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel_n,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_irq,
  input  logic [AW-1:0] cop_addr,
  input  logic          cop_rd,
  input  logic          cop_wr,
  input  logic [DW-1:0] cop_wdata,
  output logic [DW-1:0] cop_rdata,
  output logic          cop_nmi_n
);
  logic          h_rd, h_wr, c_rd, c_wr;
  logic [MB_NUM-1:0]   mb_wr, mb_rd, mb_pend;
  logic [DW-1:0]       mb_wdata [MB_NUM];
  logic [DW-1:0]       mb_data  [MB_NUM];

  mbox_host_decode u_hdec (
    .sel_n (host_sel_n), .rd (host_rd), .wr (host_wr),
    .rd_hit(h_rd), .wr_hit(h_wr)
  );

  mbox_cop_decode #(.AW(AW), .IGN_BITS(IGN_BITS), .WIN_TAG(WIN_TAG)) u_cdec (
    .addr(cop_addr), .rd(cop_rd), .wr(cop_wr),
    .rd_hit(c_rd), .wr_hit(c_wr)
  );

  // Cross-coupled routing: each side writes one mailbox and reads the other
  always_comb begin
    mb_wr[MB_DOWN]    = h_wr;
    mb_rd[MB_DOWN]    = c_rd;
    mb_wdata[MB_DOWN] = host_wdata;
    mb_wr[MB_UP]      = c_wr;
    mb_rd[MB_UP]      = h_rd;
    mb_wdata[MB_UP]   = cop_wdata;
  end

  for (genvar i = 0; i < MB_NUM; i++) begin : g_mb
    mbox_latch #(.DW(DW)) u_latch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(mb_wr[i]), .rd_en(mb_rd[i]), .wdata(mb_wdata[i]),
      .data(mb_data[i]), .pending(mb_pend[i])
    );
  end

  always_comb begin
    host_rdata = h_rd ? mb_data[MB_UP]   : '0;
    cop_rdata  = c_rd ? mb_data[MB_DOWN] : '0;
    host_irq   = mb_pend[MB_UP];
    cop_nmi_n  = ~mb_pend[MB_DOWN];
  end

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(cop_wr && cop_addr[AW-1:IGN_BITS] == WIN_TAG));
  // R5
  nmi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cop_nmi_n) |-> $past(!host_sel_n && host_wr));
endmodule

// File: tb/mbox_pair_tb.sv
module mbox_pair_tb;
  logic        clk, rst_n;
  logic        host_sel_n, host_rd, host_wr;
  logic [7:0]  host_wdata, host_rdata;
  logic        host_irq;
  logic [15:0] cop_addr;
  logic        cop_rd, cop_wr;
  logic [7:0]  cop_wdata, cop_rdata;
  logic        cop_nmi_n;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  mbox_pair u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_sel_n(host_sel_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
    .cop_addr(cop_addr), .cop_rd(cop_rd), .cop_wr(cop_wr),
    .cop_wdata(cop_wdata), .cop_rdata(cop_rdata), .cop_nmi_n(cop_nmi_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Each op starts at a negedge, samples comb read data, ends at next negedge
  task automatic cop_op(input bit rd, input bit wr, input logic [15:0] a,
                        input logic [7:0] d, output logic [7:0] q);
    cop_rd = rd; cop_wr = wr; cop_addr = a; cop_wdata = d;
    #2 q = cop_rdata;
    @(negedge clk);
    cop_rd = 1'b0; cop_wr = 1'b0;
  endtask

  task automatic host_op(input bit sel, input bit rd, input bit wr,
                         input logic [7:0] d, output logic [7:0] q);
    host_sel_n = ~sel; host_rd = rd; host_wr = wr; host_wdata = d;
    #2 q = host_rdata;
    @(negedge clk);
    host_sel_n = 1'b1; host_rd = 1'b0; host_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] q;
    chk(host_irq == 1'b0, "R1 irq", host_irq, 0);
    chk(cop_nmi_n == 1'b1, "R1 nmi_n", cop_nmi_n, 1);
    chk(cop_rdata == 8'h00, "R2 idle cop_rdata", cop_rdata, 0);
    host_op(1, 1, 0, 8'h00, q);
    chk(q == 8'h00, "R1 upstream data", q, 0);
    cop_op(1, 0, 16'h7F00, 8'h00, q);
    chk(q == 8'h00, "R1 downstream data", q, 0);
  endtask

  task automatic t_down();
    logic [7:0] q;
    host_op(1, 0, 1, 8'hA5, q);
    chk(cop_nmi_n == 1'b0, "R5 nmi low after write", cop_nmi_n, 0);
    chk(host_irq == 1'b0, "R10 irq untouched", host_irq, 0);
    cop_op(1, 0, 16'h7F00, 8'h00, q);
    chk(q == 8'hA5, "R3 cop reads downstream", q, 8'hA5);
    chk(cop_nmi_n == 1'b1, "R7 nmi cleared by read", cop_nmi_n, 1);
    cop_op(1, 0, 16'h7F42, 8'h00, q);
    chk(q == 8'hA5, "R7 data kept after read", q, 8'hA5);
  endtask

  task automatic t_up();
    logic [7:0] q;
    cop_op(0, 1, 16'h7F3C, 8'h5A, q);
    chk(host_irq == 1'b1, "R6 irq high after write", host_irq, 1);
    chk(cop_nmi_n == 1'b1, "R10 nmi untouched", cop_nmi_n, 1);
    host_op(1, 1, 0, 8'h00, q);
    chk(q == 8'h5A, "R4 host reads upstream", q, 8'h5A);
    chk(host_irq == 1'b0, "R7 irq cleared by read", host_irq, 0);
    host_op(1, 0, 0, 8'h00, q);
    chk(q == 8'h00, "R4 host_rdata idle", q, 0);
  endtask

  task automatic t_mirror();
    logic [7:0] q;
    cop_op(0, 1, 16'h7FFF, 8'hC3, q);
    host_op(1, 1, 0, 8'h00, q);
    chk(q == 8'hC3, "R2 top mirror write", q, 8'hC3);
    cop_op(0, 1, 16'h7E00, 8'h11, q);
    chk(host_irq == 1'b0, "R2 below window write", host_irq, 0);
    cop_op(0, 1, 16'hFF00, 8'h22, q);
    chk(host_irq == 1'b0, "R2 A15 set write", host_irq, 0);
    host_op(1, 1, 0, 8'h00, q);
    chk(q == 8'hC3, "R2 out-of-window data kept", q, 8'hC3);
    host_op(1, 0, 1, 8'h3E, q);
    cop_op(1, 0, 16'h8000, 8'h00, q);
    chk(q == 8'h00, "R2 out-of-window read data", q, 0);
    chk(cop_nmi_n == 1'b0, "R2 out-of-window read no clear", cop_nmi_n, 0);
    cop_op(1, 0, 16'h7F80, 8'h00, q);
    chk(q == 8'h3E, "R2 mid mirror read", q, 8'h3E);
  endtask

  task automatic t_select();
    logic [7:0] q;
    host_op(0, 0, 1, 8'h99, q);
    chk(cop_nmi_n == 1'b1, "R9 deselected write no flag", cop_nmi_n, 1);
    cop_op(1, 0, 16'h7F00, 8'h00, q);
    chk(q == 8'h3E, "R9 deselected write no data", q, 8'h3E);
    cop_op(0, 1, 16'h7F01, 8'h66, q);
    host_op(0, 1, 0, 8'h00, q);
    chk(q == 8'h00, "R9 deselected read data", q, 0);
    chk(host_irq == 1'b1, "R9 deselected read no clear", host_irq, 1);
    host_op(1, 1, 0, 8'h00, q);
  endtask

  task automatic t_collide();
    logic [7:0] q;
    host_op(1, 0, 1, 8'h10, q);
    host_sel_n = 1'b0; host_wr = 1'b1; host_wdata = 8'h77;
    cop_rd = 1'b1; cop_addr = 16'h7F05;
    #2 chk(cop_rdata == 8'h10, "R8 old byte during collide", cop_rdata, 8'h10);
    @(negedge clk);
    host_sel_n = 1'b1; host_wr = 1'b0; cop_rd = 1'b0;
    chk(cop_nmi_n == 1'b0, "R8 write wins flag", cop_nmi_n, 0);
    cop_op(1, 0, 16'h7F00, 8'h00, q);
    chk(q == 8'h77, "R8 write wins data", q, 8'h77);
    chk(cop_nmi_n == 1'b1, "R8 later read clears", cop_nmi_n, 1);
  endtask

  task automatic t_indep();
    logic [7:0] q;
    host_op(1, 0, 1, 8'hE1, q);
    cop_op(0, 1, 16'h7FAA, 8'h1E, q);
    chk(host_irq == 1'b1 && cop_nmi_n == 1'b0, "R10 both pending", {host_irq, cop_nmi_n}, 2'b10);
    host_op(1, 1, 0, 8'h00, q);
    chk(q == 8'h1E, "R10 upstream data", q, 8'h1E);
    chk(cop_nmi_n == 1'b0, "R10 host read keeps nmi", cop_nmi_n, 0);
    cop_op(1, 0, 16'h7F00, 8'h00, q);
    chk(q == 8'hE1, "R10 downstream data", q, 8'hE1);
    chk(host_irq == 1'b0 && cop_nmi_n == 1'b1, "R10 both clear", {host_irq, cop_nmi_n}, 2'b01);
  endtask

  initial begin
    rst_n = 1'b0;
    host_sel_n = 1'b1; host_rd = 1'b0; host_wr = 1'b0; host_wdata = '0;
    cop_addr = '0; cop_rd = 1'b0; cop_wr = 1'b0; cop_wdata = '0;
    repeat (3) @(negedge clk);
    chk(host_irq == 1'b0 && cop_nmi_n == 1'b1, "R1 during reset", {host_irq, cop_nmi_n}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_down();
    t_up();
    t_mirror();
    t_select();
    t_collide();
    t_indep();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
    end
  end
endmodule